// File: doc/BRIEF.md
# Banked Video Memory Mapping Decoder

This block decides where nine video memory banks appear on three buses: the main CPU bus, the secondary CPU bus and a bus used only by the graphics engines. Each bank has an 8-bit control byte. The byte holds an enable bit, a 3-bit placement mode and a 2-bit offset choice. From that byte and a fixed per-bank table, the block works out the area the bank occupies, its start address, and whether it repeats across the area. Areas are built from 16 KiB slots, and one slot may hold more than one bank.

Each bus has a combinational lookup port. Given an address, it returns three things: a 9-bit mask of the banks that answer, the address inside each bank, and a write-enable mask. When banks overlap, a write goes to all of them. On a read, the port merges the banks' read data by bitwise OR. The bank storage arrays live outside the block; their read data comes back in through `bank_rdata`. A status output tells the secondary CPU when one of its banks is present.

Top module: `vmap_decoder`

## Requirements
- R1: Control bytes are written through `cfg_we`/`cfg_sel`/`cfg_wdata` and read back on `cfg_rdata` masked with 0x9F. Selections 9 to 15 store nothing and read 0. After synchronous reset every byte is 0.
- R2: Bit 7 of a control byte enables the bank. With bit 7 clear, the bank hits on no bus.
- R3: Bits 2:0 select the mode. The start address is the mode base, plus increment 1 when bit 3 is set, plus increment 2 when bit 4 is set. The bank number is the `cfg_sel` value. Entries are written as mode: area base/increment 1/increment 2/stride, in hexadecimal.
  - Banks 0 and 1:
    - mode 0: display-direct at 6800000 (bank 0) or 6820000 (bank 1).
    - mode 1: bg-A 6000000/20000/40000/80000.
    - mode 2: obj-A 6400000/20000/0/40000.
    - mode 3: texture 5000000/20000/40000/0.
  - Banks 2 and 3:
    - mode 0: display-direct at 6840000 (bank 2) or 6860000 (bank 3).
    - modes 1 and 3: as for banks 0 and 1.
    - mode 2: secondary 6000000/20000/0/0.
    - mode 4: bg-B 6200000 stride 20000 for bank 2, obj-B 6600000 stride 20000 for bank 3.
  - Bank 4:
    - mode 0: display-direct at 6880000.
    - mode 1: bg-A 6000000 stride 80000.
    - mode 2: obj-A 6400000 stride 40000.
    - mode 3: texture-palette 6000000.
    - mode 4: bg-extpal-A 1000000.
  - Banks 5 and 6:
    - mode 0: display-direct at 6890000 (bank 5) or 6894000 (bank 6).
    - mode 1: bg-A 6000000/4000/10000/80000.
    - mode 2: obj-A 6400000/4000/10000/40000.
    - mode 3: texture-palette 6000000/4000/10000/0.
    - mode 4: bg-extpal-A 1000000/4000/0/0.
    - mode 5: obj-extpal-A 2000000.
  - Bank 7:
    - mode 0: display-direct at 6898000.
    - mode 1: bg-B 6200000 stride 10000.
    - mode 2: bg-extpal-B 3000000.
  - Bank 8:
    - mode 0: display-direct at 68A0000.
    - mode 1: bg-B 6208000 stride 10000.
    - mode 2: obj-B 6600000 stride 4000.
    - mode 3: obj-extpal-B 4000000.
  - Any other mode leaves the bank unmapped.
- R4: Bank sizes in KiB are 128, 128, 128, 128, 64, 16, 16, 32 and 16. An address from start to start+size-1 hits the bank, with bank-local address equal to address minus start. The address just below the start does not hit.
- R5: With a nonzero stride, the bank also answers at start+k·stride for every whole copy that lies inside the area. A zero stride gives a single copy.
- R6: Areas and their ranges:
  - Main bus: display-direct 6800000–68A3FFF, bg-A 6000000–61FFFFF, bg-B 6200000–63FFFFF, obj-A 6400000–65FFFFF, obj-B 6600000–67FFFFF.
  - Secondary bus: secondary 6000000–603FFFF.
  - Graphics bus: bg-extpal-A 1000000–100FFFF, obj-extpal-A 2000000–2003FFF, bg-extpal-B 3000000–3007FFF, obj-extpal-B 4000000–4003FFF, texture 5000000–507FFFF, texture-palette 6000000–6017FFF.
  - A mapped bank hits only on its area's bus, and never outside its area.
- R7: Banks that share an address all set their hit bits. A non-byte write enables all of them, and the read data is the OR of their `bank_rdata` words.
- R8: An address that hits no bank reads 0 and enables no write.
- R9: Byte writes (`x_byte`=1) give an all-zero write mask on the main and graphics buses. They are accepted on the secondary bus.
- R10: Rewriting a control byte removes the bank from its previous placement in the same cycle that the new placement takes effect.
- R11: `sec_owned` is 1 exactly when bank 2 or bank 3 is enabled in mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_sel | input | 4 | Bank number for write and readback |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte of selected bank |
| sec_owned | output | 1 | Bank 2 or 3 placed on secondary bus |
| bank_rdata | input | 9*DW | Read data of each bank, bank 0 lowest |
| m_addr | input | 28 | Main bus address |
| m_wr | input | 1 | Main bus write |
| m_byte | input | 1 | Main bus byte-wide access |
| m_hit | output | 9 | Main bus bank hit mask |
| m_wen | output | 9 | Main bus bank write enables |
| m_off | output | 9*17 | Main bus bank-local addresses |
| m_rdata | output | DW | Main bus merged read data |
| s_addr | input | 28 | Secondary bus address |
| s_wr | input | 1 | Secondary bus write |
| s_byte | input | 1 | Secondary bus byte-wide access |
| s_hit | output | 9 | Secondary bus bank hit mask |
| s_wen | output | 9 | Secondary bus bank write enables |
| s_off | output | 9*17 | Secondary bus bank-local addresses |
| s_rdata | output | DW | Secondary bus merged read data |
| g_addr | input | 28 | Graphics bus address |
| g_wr | input | 1 | Graphics bus write |
| g_byte | input | 1 | Graphics bus byte-wide access |
| g_hit | output | 9 | Graphics bus bank hit mask |
| g_wen | output | 9 | Graphics bus bank write enables |
| g_off | output | 9*17 | Graphics bus bank-local addresses |
| g_rdata | output | DW | Graphics bus merged read data |

## Verification
Two placements rarely line up at the ports by accident. The hardest case to reach is therefore two banks answering the same address: it only happens when two control bytes are deliberately pointed at the same area. The bench programs a 128 KiB bank and a 64 KiB bank into the same background area at the same start. It then checks the merged read data and both write masks. The mirror rule is the other hard edge: the bench probes the first repeated copy inside the area, or the byte just past a single copy, for every bank, mode and offset combination.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
    localparam int NBANK = 9;
    localparam int AW    = 28;
    localparam int LW    = 17;

    typedef enum logic [1:0] {BUS_MAIN = 2'd0, BUS_SEC = 2'd1, BUS_GFX = 2'd2} bus_e;

    typedef enum logic [3:0] {
        AR_LCD, AR_BGA, AR_BGB, AR_OBJA, AR_OBJB, AR_SEC,
        AR_BGXA, AR_OBJXA, AR_BGXB, AR_OBJXB, AR_TEX, AR_TPAL
    } area_e;

    typedef struct packed {
        logic          valid;
        area_e         area;
        logic [AW-1:0] base;
        logic [AW-1:0] inc0;
        logic [AW-1:0] inc1;
        logic [AW-1:0] stride;
    } mode_t;

    typedef struct packed {
        logic          valid;
        bus_e          bus;
        logic [AW-1:0] start;
        logic [AW-1:0] stop;
        logic [AW-1:0] stride;
        logic [4:0]    size_lg;
    } place_t;

    function automatic bus_e area_bus(area_e a);
        case (a)
            AR_SEC:                                             return BUS_SEC;
            AR_BGXA, AR_OBJXA, AR_BGXB, AR_OBJXB, AR_TEX, AR_TPAL: return BUS_GFX;
            default:                                            return BUS_MAIN;
        endcase
    endfunction

    // exclusive end address of each area
    function automatic logic [AW-1:0] area_hi(area_e a);
        case (a)
            AR_LCD:   return 28'h68A4000;
            AR_BGA:   return 28'h6200000;
            AR_BGB:   return 28'h6400000;
            AR_OBJA:  return 28'h6600000;
            AR_OBJB:  return 28'h6800000;
            AR_SEC:   return 28'h6040000;
            AR_BGXA:  return 28'h1010000;
            AR_OBJXA: return 28'h2004000;
            AR_BGXB:  return 28'h3008000;
            AR_OBJXB: return 28'h4004000;
            AR_TEX:   return 28'h5080000;
            default:  return 28'h6018000;
        endcase
    endfunction

    function automatic logic [4:0] bank_size_lg(int b);
        case (b)
            0, 1, 2, 3: return 5'd17;
            4:          return 5'd16;
            7:          return 5'd15;
            default:    return 5'd14;
        endcase
    endfunction

    function automatic mode_t mk(area_e a, logic [AW-1:0] base, logic [AW-1:0] i0,
                                 logic [AW-1:0] i1, logic [AW-1:0] st);
        mode_t r;
        r.valid = 1'b1; r.area = a; r.base = base;
        r.inc0 = i0; r.inc1 = i1; r.stride = st;
        return r;
    endfunction

    function automatic logic [AW-1:0] lcd_base(int b);
        case (b)
            0: return 28'h6800000;  1: return 28'h6820000;  2: return 28'h6840000;
            3: return 28'h6860000;  4: return 28'h6880000;  5: return 28'h6890000;
            6: return 28'h6894000;  7: return 28'h6898000;  default: return 28'h68A0000;
        endcase
    endfunction

    function automatic mode_t mode_entry(int b, logic [2:0] m);
        mode_t r = '0;
        if (m == 3'd0) return mk(AR_LCD, lcd_base(b), '0, '0, '0);
        case (b)
            0, 1, 2, 3: begin
                if (m == 3'd1) r = mk(AR_BGA, 28'h6000000, 28'h20000, 28'h40000, 28'h80000);
                if (m == 3'd3) r = mk(AR_TEX, 28'h5000000, 28'h20000, 28'h40000, '0);
                if (m == 3'd2 && b < 2) r = mk(AR_OBJA, 28'h6400000, 28'h20000, '0, 28'h40000);
                if (m == 3'd2 && b >= 2) r = mk(AR_SEC, 28'h6000000, 28'h20000, '0, '0);
                if (m == 3'd4 && b == 2) r = mk(AR_BGB, 28'h6200000, '0, '0, 28'h20000);
                if (m == 3'd4 && b == 3) r = mk(AR_OBJB, 28'h6600000, '0, '0, 28'h20000);
            end
            4: case (m)
                3'd1: r = mk(AR_BGA, 28'h6000000, '0, '0, 28'h80000);
                3'd2: r = mk(AR_OBJA, 28'h6400000, '0, '0, 28'h40000);
                3'd3: r = mk(AR_TPAL, 28'h6000000, '0, '0, '0);
                3'd4: r = mk(AR_BGXA, 28'h1000000, '0, '0, '0);
                default: r = '0;
            endcase
            5, 6: case (m)
                3'd1: r = mk(AR_BGA, 28'h6000000, 28'h4000, 28'h10000, 28'h80000);
                3'd2: r = mk(AR_OBJA, 28'h6400000, 28'h4000, 28'h10000, 28'h40000);
                3'd3: r = mk(AR_TPAL, 28'h6000000, 28'h4000, 28'h10000, '0);
                3'd4: r = mk(AR_BGXA, 28'h1000000, 28'h4000, '0, '0);
                3'd5: r = mk(AR_OBJXA, 28'h2000000, '0, '0, '0);
                default: r = '0;
            endcase
            7: case (m)
                3'd1: r = mk(AR_BGB, 28'h6200000, '0, '0, 28'h10000);
                3'd2: r = mk(AR_BGXB, 28'h3000000, '0, '0, '0);
                default: r = '0;
            endcase
            default: case (m)
                3'd1: r = mk(AR_BGB, 28'h6208000, '0, '0, 28'h10000);
                3'd2: r = mk(AR_OBJB, 28'h6600000, '0, '0, 28'h4000);
                3'd3: r = mk(AR_OBJXB, 28'h4000000, '0, '0, '0);
                default: r = '0;
            endcase
        endcase
        return r;
    endfunction
endpackage

// File: rtl/vmap_ctl_regs.sv
module vmap_ctl_regs
    import vmap_pkg::*;
#(
    parameter int NB   = NBANK,
    parameter int SELW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [SELW-1:0]      sel,
    input  logic [7:0]           wdata,
    output logic [NB-1:0][7:0]   ctl
);
    localparam logic [7:0]      WMASK  = 8'h9F;
    localparam logic [SELW-1:0] NB_SEL = SELW'(NB);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (we && sel < NB_SEL) begin
            ctl[sel] <= wdata & WMASK;
        end
    end

    assert_ctl_mask_R1: assert property (@(posedge clk) disable iff (rst)
        (we && sel < NB_SEL) |=> ctl[$past(sel)] == ($past(wdata) & WMASK));

    assert_ctl_oob_R1: assert property (@(posedge clk) disable iff (rst)
        (we && sel >= NB_SEL) |=> $stable(ctl));
endmodule

// File: rtl/vmap_place.sv
module vmap_place
    import vmap_pkg::*;
#(
    parameter int BANK = 0
) (
    input  logic       en,
    input  logic [1:0] ofs,
    input  logic [2:0] mode,
    output place_t     pl
);
    mode_t ent;

    always_comb begin
        ent        = mode_entry(BANK, mode);
        pl.valid   = en && ent.valid;
        pl.bus     = area_bus(ent.area);
        pl.start   = ent.base + (ofs[0] ? ent.inc0 : '0) + (ofs[1] ? ent.inc1 : '0);
        pl.stop    = area_hi(ent.area);
        pl.stride  = ent.stride;
        pl.size_lg = bank_size_lg(BANK);
    end
endmodule

// File: rtl/vmap_lookup.sv
module vmap_lookup
    import vmap_pkg::*;
#(
    parameter bus_e BUS = BUS_MAIN,
    parameter int   DW  = 16
) (
    input  place_t [NBANK-1:0] pl,
    input  logic [AW-1:0]      addr,
    input  logic               wr,
    input  logic               byte_acc,
    input  logic [NBANK*DW-1:0] bank_rdata,
    output logic [NBANK-1:0]   hit,
    output logic [NBANK-1:0]   wen,
    output logic [NBANK*LW-1:0] off,
    output logic [DW-1:0]      rdata
);
    localparam bit BYTE_OK = (BUS == BUS_SEC);

    logic [NBANK-1:0][DW-1:0] rd_sel;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [AW-1:0] rel, sz, win;
        assign rel = addr - pl[b].start;
        assign sz  = AW'(1) << pl[b].size_lg;
        assign win = (pl[b].stride == '0) ? rel : (rel & (pl[b].stride - AW'(1)));
        assign hit[b] = pl[b].valid && (pl[b].bus == BUS) &&
                        (addr >= pl[b].start) && (addr < pl[b].stop) && (win < sz);
        assign off[b*LW +: LW] = rel[LW-1:0] & LW'(sz - AW'(1));
        assign rd_sel[b] = hit[b] ? bank_rdata[b*DW +: DW] : '0;
    end

    assign wen = (wr && (BYTE_OK || !byte_acc)) ? hit : '0;

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NBANK; b++) rdata |= rd_sel[b];
    end
endmodule

// File: rtl/vmap_decoder.sv
module vmap_decoder
    import vmap_pkg::*;
#(
    parameter int DW   = 16,
    parameter int SELW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [SELW-1:0]      cfg_sel,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    output logic                 sec_owned,
    input  logic [9*DW-1:0]      bank_rdata,
    input  logic [27:0]          m_addr,
    input  logic                 m_wr,
    input  logic                 m_byte,
    output logic [8:0]           m_hit,
    output logic [8:0]           m_wen,
    output logic [9*17-1:0]      m_off,
    output logic [DW-1:0]        m_rdata,
    input  logic [27:0]          s_addr,
    input  logic                 s_wr,
    input  logic                 s_byte,
    output logic [8:0]           s_hit,
    output logic [8:0]           s_wen,
    output logic [9*17-1:0]      s_off,
    output logic [DW-1:0]        s_rdata,
    input  logic [27:0]          g_addr,
    input  logic                 g_wr,
    input  logic                 g_byte,
    output logic [8:0]           g_hit,
    output logic [8:0]           g_wen,
    output logic [9*17-1:0]      g_off,
    output logic [DW-1:0]        g_rdata
);
    localparam int NBUS = 3;

    logic [NBANK-1:0][7:0] ctl;
    place_t [NBANK-1:0]    pl;

    logic [AW-1:0]       la   [NBUS];
    logic                lwr  [NBUS];
    logic                lby  [NBUS];
    logic [NBANK-1:0]    lhit [NBUS];
    logic [NBANK-1:0]    lwen [NBUS];
    logic [NBANK*LW-1:0] loff [NBUS];
    logic [DW-1:0]       lrd  [NBUS];

    vmap_ctl_regs #(.NB(NBANK), .SELW(SELW)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata), .ctl(ctl)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_place
        vmap_place #(.BANK(b)) u_place (
            .en(ctl[b][7]), .ofs(ctl[b][4:3]), .mode(ctl[b][2:0]), .pl(pl[b])
        );
    end

    assign la[0] = m_addr;  assign lwr[0] = m_wr;  assign lby[0] = m_byte;
    assign la[1] = s_addr;  assign lwr[1] = s_wr;  assign lby[1] = s_byte;
    assign la[2] = g_addr;  assign lwr[2] = g_wr;  assign lby[2] = g_byte;

    for (genvar k = 0; k < NBUS; k++) begin : g_bus
        vmap_lookup #(.BUS(bus_e'(k)), .DW(DW)) u_look (
            .pl(pl), .addr(la[k]), .wr(lwr[k]), .byte_acc(lby[k]),
            .bank_rdata(bank_rdata), .hit(lhit[k]), .wen(lwen[k]),
            .off(loff[k]), .rdata(lrd[k])
        );
    end

    assign m_hit = lhit[0];  assign m_wen = lwen[0];  assign m_off = loff[0];  assign m_rdata = lrd[0];
    assign s_hit = lhit[1];  assign s_wen = lwen[1];  assign s_off = loff[1];  assign s_rdata = lrd[1];
    assign g_hit = lhit[2];  assign g_wen = lwen[2];  assign g_off = loff[2];  assign g_rdata = lrd[2];

    assign cfg_rdata = (cfg_sel < SELW'(NBANK)) ? ctl[cfg_sel] : 8'h00;
    assign sec_owned = (pl[2].valid && pl[2].bus == BUS_SEC) ||
                       (pl[3].valid && pl[3].bus == BUS_SEC);

    for (genvar b = 0; b < NBANK; b++) begin : g_chk
        assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
            !ctl[b][7] |-> !(m_hit[b] || s_hit[b] || g_hit[b]));
    end

    assert_sec_banks_R6: assert property (@(posedge clk) disable iff (rst)
        (s_hit & 9'b111110011) == 9'b0);
    assert_main_byte_R9: assert property (@(posedge clk) disable iff (rst)
        (m_wr && m_byte) |-> m_wen == 9'b0);
    assert_sec_byte_R9: assert property (@(posedge clk) disable iff (rst)
        s_wr |-> s_wen == s_hit);
    assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
        (m_hit == 9'b0) |-> (m_rdata == '0 && m_wen == 9'b0));
    assert_status_R11: assert property (@(posedge clk) disable iff (rst)
        sec_owned |-> ((ctl[2][7] && ctl[2][2:0] == 3'd2) || (ctl[3][7] && ctl[3][2:0] == 3'd2)));
endmodule

// File: tb/vmap_decoder_bench.sv
module vmap_decoder_bench;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0, cfg_rdata;
    logic sec_owned;
    logic [9*DW-1:0] bank_rdata = '0;
    logic [27:0] m_addr = '0, s_addr = '0, g_addr = '0;
    logic m_wr = 0, m_byte = 0, s_wr = 0, s_byte = 0, g_wr = 0, g_byte = 0;
    logic [8:0] m_hit, m_wen, s_hit, s_wen, g_hit, g_wen;
    logic [9*17-1:0] m_off, s_off, g_off;
    logic [DW-1:0] m_rdata, s_rdata, g_rdata;

    int nchk = 0, nerr = 0;

    always #4 clk = ~clk;

    vmap_decoder u_vmap_decoder (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sec_owned(sec_owned), .bank_rdata(bank_rdata),
        .m_addr(m_addr), .m_wr(m_wr), .m_byte(m_byte), .m_hit(m_hit), .m_wen(m_wen),
        .m_off(m_off), .m_rdata(m_rdata),
        .s_addr(s_addr), .s_wr(s_wr), .s_byte(s_byte), .s_hit(s_hit), .s_wen(s_wen),
        .s_off(s_off), .s_rdata(s_rdata),
        .g_addr(g_addr), .g_wr(g_wr), .g_byte(g_byte), .g_hit(g_hit), .g_wen(g_wen),
        .g_off(g_off), .g_rdata(g_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input int b, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'(b); cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input int a);
        m_addr = 28'(a); s_addr = 28'(a); g_addr = 28'(a);
        #1;
    endtask

    function automatic int bsz(int b);
        if (b < 4) return 32'h20000;
        if (b == 4) return 32'h10000;
        if (b == 7) return 32'h8000;
        return 32'h4000;
    endfunction

    // bus codes: 0 main, 1 secondary, 2 graphics
    function automatic bit hbit(int bus, int b);
        if (bus == 0) return m_hit[b];
        if (bus == 1) return s_hit[b];
        return g_hit[b];
    endfunction

    function automatic int offv(int bus, int b);
        if (bus == 0) return int'(m_off[b*17 +: 17]);
        if (bus == 1) return int'(s_off[b*17 +: 17]);
        return int'(g_off[b*17 +: 17]);
    endfunction

    task automatic expect_map(input int b, input int m, output bit v, output int bus,
                              output int base, output int i0, output int i1,
                              output int st, output int hi);
        int lcd [9] = '{32'h6800000, 32'h6820000, 32'h6840000, 32'h6860000, 32'h6880000,
                        32'h6890000, 32'h6894000, 32'h6898000, 32'h68A0000};
        v = 1; bus = 0; base = 0; i0 = 0; i1 = 0; st = 0; hi = 0;
        if (m == 0) begin base = lcd[b]; hi = 32'h68A4000; return; end
        if (b <= 3 && m == 1) begin base = 32'h6000000; i0 = 32'h20000; i1 = 32'h40000; st = 32'h80000; hi = 32'h6200000; end
        else if (b <= 3 && m == 3) begin bus = 2; base = 32'h5000000; i0 = 32'h20000; i1 = 32'h40000; hi = 32'h5080000; end
        else if (b <= 1 && m == 2) begin base = 32'h6400000; i0 = 32'h20000; st = 32'h40000; hi = 32'h6600000; end
        else if ((b == 2 || b == 3) && m == 2) begin bus = 1; base = 32'h6000000; i0 = 32'h20000; hi = 32'h6040000; end
        else if (b == 2 && m == 4) begin base = 32'h6200000; st = 32'h20000; hi = 32'h6400000; end
        else if (b == 3 && m == 4) begin base = 32'h6600000; st = 32'h20000; hi = 32'h6800000; end
        else if (b == 4 && m == 1) begin base = 32'h6000000; st = 32'h80000; hi = 32'h6200000; end
        else if (b == 4 && m == 2) begin base = 32'h6400000; st = 32'h40000; hi = 32'h6600000; end
        else if (b == 4 && m == 3) begin bus = 2; base = 32'h6000000; hi = 32'h6018000; end
        else if (b == 4 && m == 4) begin bus = 2; base = 32'h1000000; hi = 32'h1010000; end
        else if ((b == 5 || b == 6) && m == 1) begin base = 32'h6000000; i0 = 32'h4000; i1 = 32'h10000; st = 32'h80000; hi = 32'h6200000; end
        else if ((b == 5 || b == 6) && m == 2) begin base = 32'h6400000; i0 = 32'h4000; i1 = 32'h10000; st = 32'h40000; hi = 32'h6600000; end
        else if ((b == 5 || b == 6) && m == 3) begin bus = 2; base = 32'h6000000; i0 = 32'h4000; i1 = 32'h10000; hi = 32'h6018000; end
        else if ((b == 5 || b == 6) && m == 4) begin bus = 2; base = 32'h1000000; i0 = 32'h4000; hi = 32'h1010000; end
        else if ((b == 5 || b == 6) && m == 5) begin bus = 2; base = 32'h2000000; hi = 32'h2004000; end
        else if (b == 7 && m == 1) begin base = 32'h6200000; st = 32'h10000; hi = 32'h6400000; end
        else if (b == 7 && m == 2) begin bus = 2; base = 32'h3000000; hi = 32'h3008000; end
        else if (b == 8 && m == 1) begin base = 32'h6208000; st = 32'h10000; hi = 32'h6400000; end
        else if (b == 8 && m == 2) begin base = 32'h6600000; st = 32'h4000; hi = 32'h6800000; end
        else if (b == 8 && m == 3) begin bus = 2; base = 32'h4000000; hi = 32'h4004000; end
        else v = 0;
    endtask

    initial begin : watchdog
        #1500000;
        nerr++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin : main
        bit v; int bus, base, i0, i1, st, hi, start, sz;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state (R1, R8, R11)
        for (int b = 0; b < 9; b++) begin
            cfg_sel = 4'(b); #1;
            chk(cfg_rdata == 8'h00, "R1 reset value", cfg_rdata, 0);
        end
        for (int b = 0; b < 9; b++) bank_rdata[b*DW +: DW] = 16'hA5A5;
        look(32'h6000000);
        chk(m_hit == 0 && s_hit == 0 && g_hit == 0, "R8 no hit after reset", {m_hit, s_hit, g_hit}, 0);
        chk(m_rdata == 0 && s_rdata == 0 && g_rdata == 0, "R8 unmapped read zero", m_rdata, 0);
        chk(sec_owned == 1'b0, "R11 status after reset", sec_owned, 0);

        // R1 write mask and out-of-range selection
        wr_ctl(5, 8'hFF);
        cfg_sel = 4'd5; #1;
        chk(cfg_rdata == 8'h9F, "R1 masked readback", cfg_rdata, 8'h9F);
        wr_ctl(12, 8'hFF);
        cfg_sel = 4'd5; #1;
        chk(cfg_rdata == 8'h9F, "R1 oob write keeps bank 5", cfg_rdata, 8'h9F);
        cfg_sel = 4'd12; #1;
        chk(cfg_rdata == 8'h00, "R1 oob readback zero", cfg_rdata, 0);
        wr_ctl(5, 0);

        // sweep of every bank, mode and offset
        for (int b = 0; b < 9; b++) begin
            for (int m = 0; m < 8; m++) begin
                for (int o = 0; o < 4; o++) begin
                    wr_ctl(b, 8'h80 | (o << 3) | m);
                    expect_map(b, m, v, bus, base, i0, i1, st, hi);
                    if (!v) begin
                        look(32'h6000000);
                        chk(!m_hit[b] && !s_hit[b] && !g_hit[b], "R3 unlisted mode unmapped", {m_hit, s_hit, g_hit}, 0);
                    end else begin
                        start = base + ((o & 1) ? i0 : 0) + ((o & 2) ? i1 : 0);
                        sz = bsz(b);
                        look(start);
                        chk(hbit(bus, b) && offv(bus, b) == 0, "R3 start address", start, offv(bus, b));
                        for (int k = 0; k < 3; k++)
                            if (k != bus) chk(!hbit(k, b), "R6 other bus quiet", k, bus);
                        look(start + sz - 1);
                        chk(hbit(bus, b) && offv(bus, b) == sz - 1, "R4 last byte", offv(bus, b), sz - 1);
                        look(start - 1);
                        chk(!hbit(bus, b), "R4 below start", start - 1, 0);
                        if (st != 0 && start + st + 3 < hi) begin
                            look(start + st + 3);
                            chk(hbit(bus, b) && offv(bus, b) == 3, "R5 mirror copy", offv(bus, b), 3);
                        end else begin
                            look(start + sz);
                            chk(!hbit(bus, b), "R5 single copy end", start + sz, 0);
                        end
                    end
                    wr_ctl(b, 8'h00);
                end
            end
        end

        // R2 enable clear with mode bits set
        wr_ctl(0, 8'h01);
        look(32'h6000000);
        chk(m_hit[0] == 0, "R2 disabled bank", m_hit, 0);

        // R10 remap removes old placement
        wr_ctl(0, 8'h81);
        look(32'h6000010);
        chk(m_hit[0] == 1 && m_off[16:0] == 17'h10, "R10 first placement", m_hit, 1);
        wr_ctl(0, 8'h82);
        look(32'h6000010);
        chk(m_hit[0] == 0, "R10 old placement gone", m_hit, 0);
        look(32'h6400010);
        chk(m_hit[0] == 1, "R10 new placement", m_hit, 1);

        // R7 overlap: bank 0 and bank 4 both on bg-A at 6000000
        wr_ctl(0, 8'h81);
        wr_ctl(4, 8'h81);
        bank_rdata[0*DW +: DW] = 16'h1200;
        bank_rdata[4*DW +: DW] = 16'h0034;
        look(32'h6000020);
        chk(m_hit == 9'b000010001, "R7 overlap hit mask", m_hit, 9'b000010001);
        chk(m_rdata == 16'h1234, "R7 OR of read data", m_rdata, 16'h1234);
        m_wr = 1; m_byte = 0; #1;
        chk(m_wen == 9'b000010001, "R7 write to both", m_wen, 9'b000010001);
        m_byte = 1; #1;
        chk(m_wen == 9'b0, "R9 main byte write rejected", m_wen, 0);
        m_wr = 0; m_byte = 0;
        look(32'h6010020);
        chk(m_hit == 9'b000000001 && m_rdata == 16'h1200, "R7 only wider bank", m_rdata, 16'h1200);
        look(32'h6020000);
        chk(m_hit == 0 && m_rdata == 0, "R8 gap reads zero", m_rdata, 0);
        wr_ctl(0, 0); wr_ctl(4, 0);

        // R9 graphics byte write
        wr_ctl(1, 8'h83);
        look(32'h5000000);
        g_wr = 1; g_byte = 1; #1;
        chk(g_hit[1] == 1 && g_wen == 0, "R9 graphics byte write rejected", g_wen, 0);
        g_wr = 0; g_byte = 0;
        wr_ctl(1, 0);

        // R11 status and R9 secondary byte write
        wr_ctl(2, 8'h82);
        look(32'h6000004);
        chk(sec_owned == 1, "R11 bank 2 owned", sec_owned, 1);
        s_wr = 1; s_byte = 1; #1;
        chk(s_wen == 9'b000000100, "R9 secondary byte write", s_wen, 9'b000000100);
        s_wr = 0; s_byte = 0;
        wr_ctl(2, 0);
        chk(sec_owned == 0, "R11 cleared", sec_owned, 0);
        wr_ctl(3, 8'h8A);
        look(32'h6020000);
        chk(sec_owned == 1 && s_hit == 9'b000001000, "R11 bank 3 at upper half", s_hit, 9'b000001000);
        wr_ctl(3, 8'h81);
        chk(sec_owned == 0, "R11 other mode clears", sec_owned, 0);
        wr_ctl(3, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule